// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog peripheral behind a small 32-bit register bus with single-cycle read and write strobes. A down-counter, once enabled, ticks by one each clock. When it runs out, it reloads from a programmable load value and raises an interrupt. If software has not acknowledged that interrupt by the time the counter runs out again, the block requests a system reset, provided reset generation is enabled. Software therefore programs half the intended reset period into the load register.

All configuration writes are guarded by a key-based lock. Writing the key word to the lock register opens the block, and any other value closes it again. Writing the interrupt-acknowledge register clears the pending interrupt and also restarts the count from the load value. The usual service sequence is to unlock, acknowledge, and lock again.

Top module: `lockable_watchdog`

## Requirements
- R1: After reset the block is locked, the counter is disabled, and both the load register (offset 0x000) and the counter value (offset 0x004) read 0xFFFFFFFF. Control (0x008) and status (0x014) read 0, and irqOut and rstReqOut are low.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and a write of any other value there locks it. This works in either state. Offset 0xC00 reads 1 while locked and 0 while unlocked.
- R3: While the block is locked, writes to the load, control and interrupt-acknowledge offsets change nothing. Reads return current values in either state.
- R4: Control bit 0 enables the counter and the interrupt. Control bit 1 enables reset generation. Control bits 31:2 always read as zero.
- R5: While enabled, the counter value falls by one each clock. On a cycle in which it is zero (an expiry), the next value is the load register and the interrupt becomes pending.
- R6: irqOut and status bit 0 equal "interrupt pending AND counter enabled". Status bits 31:1 read zero.
- R7: A write of any data to offset 0x00C clears the pending interrupt and sets the counter to the load value. This takes priority over an expiry in the same cycle, which then neither sets the interrupt nor requests a reset.
- R8: An expiry that occurs while the interrupt is already pending and reset generation is enabled drives rstReqOut high for exactly the following cycle. With reset generation disabled, no request is made.
- R9: A load-register write while the counter is enabled also moves the new value into the counter at once. While the counter is disabled, the write updates only the load register.
- R10: While the counter is disabled, its value and the pending interrupt are held unchanged, except by an acknowledge write.
- R11: The interrupt-acknowledge offset and all unmapped offsets read zero, and writes to unmapped offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for bus and counter |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one access per cycle |
| busRdEn | input | 1 | Read strobe, data is valid in the same cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero when no read is requested |
| irqOut | output | 1 | Interrupt: first expiry not yet acknowledged |
| rstReqOut | output | 1 | Reset request after the second unacknowledged expiry |

## Verification
The hardest state to reach is a second expiry that lands while the interrupt is still pending and reset generation is on. This needs a full reload period with no acknowledge and the right lock and control history before it. A related corner is an acknowledge write that falls in the very cycle of an expiry. The stimulus keeps random load values small and makes most random cycles idle, so that double expiries happen often. A directed pass with a load value of zero expires on every cycle, which forces the acknowledge-versus-expiry race and back-to-back reset requests. A cycle-level reference model in the bench predicts every read, the interrupt and the reset request.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int unsigned BUS_W = 32;

  // Strobes and levels passed from the register front end to the counter datapath.
  typedef struct packed {
    logic             loadWr;     // accepted write to load register
    logic             clearWr;    // accepted write to interrupt acknowledge
    logic             cntEnable;  // control bit 0
    logic             rstEnable;  // control bit 1
    logic [BUS_W-1:0] wrData;     // bus write data
  } wdg_strobe_t;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  loadVal,
  input  logic              pending,
  output wdg_strobe_t       strobe,
  output logic              locked,
  output logic [BUS_W-1:0]  busRdata
);

  localparam logic [ADDR_W-1:0] OFF_LOAD  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] OFF_VALUE = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] OFF_CLEAR = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] OFF_STAT  = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] OFF_LOCK  = ADDR_W'(12'hC00);

  logic lockReg;
  logic enReg;
  logic rstEnReg;
  logic openWr;

  assign openWr = busWrEn && !lockReg;

  // The lock register itself accepts writes in either state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockReg <= 1'b1;
    end else if (busWrEn && busAddr == OFF_LOCK) begin
      lockReg <= (busWdata != LOCK_KEY);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= 1'b0;
      rstEnReg <= 1'b0;
    end else if (openWr && busAddr == OFF_CTRL) begin
      enReg    <= busWdata[0];
      rstEnReg <= busWdata[1];
    end
  end

  always_comb begin
    strobe.loadWr    = openWr && busAddr == OFF_LOAD;
    strobe.clearWr   = openWr && busAddr == OFF_CLEAR;
    strobe.cntEnable = enReg;
    strobe.rstEnable = rstEnReg;
    strobe.wrData    = busWdata;
  end

  assign locked = lockReg;

  always_comb begin
    busRdata = '0;
    if (busRdEn) begin
      unique case (busAddr)
        OFF_LOAD:  busRdata = BUS_W'(loadVal);
        OFF_VALUE: busRdata = BUS_W'(cntVal);
        OFF_CTRL:  busRdata = {{(BUS_W-2){1'b0}}, rstEnReg, enReg};
        OFF_STAT:  busRdata = {{(BUS_W-1){1'b0}}, pending && enReg};
        OFF_LOCK:  busRdata = {{(BUS_W-1){1'b0}}, lockReg};
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter bit          HOLD_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdg_strobe_t      strobe,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] loadVal,
  output logic             pending,
  output logic             irqOut,
  output logic             rstReqOut
);

  logic [CNT_W-1:0] cntReg;
  logic [CNT_W-1:0] loadReg;
  logic [CNT_W-1:0] newLoad;
  logic             pendReg;
  logic             expire;
  logic             rstFire;
  logic             rstReg;

  assign newLoad = strobe.wrData[CNT_W-1:0];
  assign expire  = strobe.cntEnable && (cntReg == '0);
  assign rstFire = expire && !strobe.clearWr && pendReg && strobe.rstEnable;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadReg <= '1;
    end else if (strobe.loadWr) begin
      loadReg <= newLoad;
    end
  end

  // Acknowledge beats a live reload, which beats an expiry reload.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg <= '1;
    end else if (strobe.clearWr) begin
      cntReg <= loadReg;
    end else if (strobe.loadWr && strobe.cntEnable) begin
      cntReg <= newLoad;
    end else if (expire) begin
      cntReg <= loadReg;
    end else if (strobe.cntEnable) begin
      cntReg <= cntReg - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= 1'b0;
    end else if (strobe.clearWr) begin
      pendReg <= 1'b0;
    end else if (expire) begin
      pendReg <= 1'b1;
    end
  end

  generate
    if (HOLD_RST) begin : g_heldReq
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rstReg <= 1'b0;
        else       rstReg <= rstReg || rstFire;
      end
    end else begin : g_pulseReq
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) rstReg <= 1'b0;
        else       rstReg <= rstFire;
      end
    end
  endgenerate

  assign cntVal    = cntReg;
  assign loadVal   = loadReg;
  assign pending   = pendReg;
  assign irqOut    = pendReg && strobe.cntEnable;
  assign rstReqOut = rstReg;

endmodule

// File: rtl/lockable_watchdog.sv
module lockable_watchdog
  import wdg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1ACC_E551,
  parameter bit          HOLD_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqOut,
  output logic              rstReqOut
);

  wdg_strobe_t      strobe;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] loadVal;
  logic             pending;
  logic             locked;

  wdg_regs #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .LOCK_KEY(LOCK_KEY)
  ) i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busWdata(busWdata),
    .cntVal  (cntVal),
    .loadVal (loadVal),
    .pending (pending),
    .strobe  (strobe),
    .locked  (locked),
    .busRdata(busRdata)
  );

  wdg_counter #(
    .CNT_W   (CNT_W),
    .HOLD_RST(HOLD_RST)
  ) i_counter (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cntVal   (cntVal),
    .loadVal  (loadVal),
    .pending  (pending),
    .irqOut   (irqOut),
    .rstReqOut(rstReqOut)
  );

endmodule

// File: rtl/lockable_watchdog_chk.sv
module lockable_watchdog_chk #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CNT_W    = 32,
  parameter logic [31:0] LOCK_KEY = 32'h1ACC_E551
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWdata,
  input logic              irqOut,
  input logic              rstReqOut,
  input logic              locked,
  input logic              enabled,
  input logic              rstEnabled,
  input logic              pending,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  loadVal
);

  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_CLEAR = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_LOCK  = ADDR_W'(12'hC00);

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == A_LOCK && busWdata == LOCK_KEY) |=> !locked);

  a_r3_locked_load_stable: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWrEn && busAddr == A_LOAD) |=> $stable(loadVal));

  a_r7_ack_drops_irq: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !locked && busAddr == A_CLEAR) |=> !irqOut);

  a_r8_reset_needs_pending: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReqOut) |-> $past(pending && enabled && rstEnabled && cntVal == '0));

  a_r10_disabled_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!enabled && !(busWrEn && !locked)) |=> $stable(cntVal));

endmodule

bind lockable_watchdog lockable_watchdog_chk #(
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W),
  .LOCK_KEY(LOCK_KEY)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busWdata  (busWdata),
  .irqOut    (irqOut),
  .rstReqOut (rstReqOut),
  .locked    (locked),
  .enabled   (strobe.cntEnable),
  .rstEnabled(strobe.rstEnable),
  .pending   (pending),
  .cntVal    (cntVal),
  .loadVal   (loadVal)
);

// File: tb/test_lockable_watchdog.sv
module test_lockable_watchdog;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] KEY    = 32'h1ACC_E551;
  localparam logic [11:0] A_LOAD = 12'h000;
  localparam logic [11:0] A_VAL  = 12'h004;
  localparam logic [11:0] A_CTRL = 12'h008;
  localparam logic [11:0] A_CLR  = 12'h00C;
  localparam logic [11:0] A_STAT = 12'h014;
  localparam logic [11:0] A_LOCK = 12'hC00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        rstReqOut;

  int checks = 0;
  int errors = 0;

  // Reference model state
  bit          mLocked, mEn, mRstEn, mPend, mRst;
  logic [31:0] mLoad, mCnt;

  always #2.5 clk = ~clk;

  lockable_watchdog i_lockable_watchdog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .rstReqOut(rstReqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] expRead(input logic [11:0] a);
    case (a)
      A_LOAD:  return mLoad;
      A_VAL:   return mCnt;
      A_CTRL:  return {30'b0, mRstEn, mEn};
      A_STAT:  return {31'b0, mPend && mEn};
      A_LOCK:  return {31'b0, mLocked};
      default: return 32'h0;  // includes acknowledge offset (R11)
    endcase
  endfunction

  function automatic void modelReset();
    mLocked = 1; mEn = 0; mRstEn = 0; mPend = 0; mRst = 0;
    mLoad = '1; mCnt = '1;
  endfunction

  function automatic void modelStep(input bit wr, input logic [11:0] a, input logic [31:0] d);
    bit ex, clr, ldw, ctl, fire;
    ex   = mEn && (mCnt == 0);
    clr  = wr && !mLocked && a == A_CLR;
    ldw  = wr && !mLocked && a == A_LOAD;
    ctl  = wr && !mLocked && a == A_CTRL;
    fire = ex && !clr && mPend && mRstEn;
    if (clr)             mCnt = mLoad;
    else if (ldw && mEn) mCnt = d;
    else if (ex)         mCnt = mLoad;
    else if (mEn)        mCnt = mCnt - 1;
    if (clr)     mPend = 0;
    else if (ex) mPend = 1;
    if (ldw) mLoad = d;
    if (ctl) begin mEn = d[0]; mRstEn = d[1]; end
    if (wr && a == A_LOCK) mLocked = (d != KEY);
    mRst = fire;
  endfunction

  // One bus cycle: drive after the falling edge, compare, clock, update model.
  task automatic step(input bit wr, input bit rd, input logic [11:0] a,
                      input logic [31:0] d, input string tag);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWdata = d;
    #1;
    if (rd) check(tag, busRdata, expRead(a));
    check("R6 irqOut", {31'b0, irqOut}, {31'b0, mPend && mEn});
    check("R8 rstReqOut", {31'b0, rstReqOut}, {31'b0, mRst});
    @(posedge clk);
    modelStep(wr, a, d);
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1, 0, a, d, "");
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    step(0, 1, a, 32'h0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 12'h0, 32'h0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_LOCK, "R1 lock");
    rd(A_LOAD, "R1 load");
    rd(A_VAL,  "R1 value");
    rd(A_CTRL, "R1 ctrl");
    rd(A_STAT, "R1 status");

    // R3 locked writes ignored
    wr(A_LOAD, 32'd5);
    wr(A_CTRL, 32'd3);
    wr(A_CLR, 32'd1);
    rd(A_LOAD, "R3 load");
    rd(A_CTRL, "R3 ctrl");
    rd(A_VAL,  "R3 value");

    // R2 lock key
    wr(A_LOCK, KEY);
    rd(A_LOCK, "R2 unlocked");
    wr(A_LOCK, 32'h0);
    rd(A_LOCK, "R2 relocked");
    wr(A_LOCK, KEY);

    // R4 reserved control bits
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, "R4 ctrl");
    idle(3);
    rd(A_VAL, "R5 value");
    wr(A_CTRL, 32'h0);
    idle(2);
    rd(A_VAL, "R10 hold");

    // R9 load while disabled, then acknowledge reloads (R7)
    wr(A_LOAD, 32'd4);
    rd(A_VAL, "R9 disabled load");
    wr(A_CLR, 32'h0);
    rd(A_VAL, "R7 reload");
    wr(A_CTRL, 32'h1);
    for (int i = 0; i < 12; i++) begin
      rd(A_VAL, "R5 count");
      rd(A_STAT, "R6 status");
    end
    // R8 reset disabled: two more expiries without request
    idle(12);
    wr(A_CLR, 32'h0);
    wr(A_CTRL, 32'h3);
    idle(14);
    // R10 disabled keeps pending and value
    wr(A_CTRL, 32'h2);
    rd(A_STAT, "R10 status masked");
    rd(A_VAL, "R10 value");
    wr(A_CTRL, 32'h3);
    rd(A_STAT, "R10 pending kept");

    // R9 load while enabled
    wr(A_LOAD, 32'd9);
    rd(A_VAL, "R9 live load");

    // Load 0: expiry every cycle, acknowledge races expiry (R7)
    wr(A_LOAD, 32'd0);
    idle(4);
    wr(A_CLR, 32'h0);
    rd(A_STAT, "R7 ack wins");
    idle(3);
    wr(A_CLR, 32'h0);
    idle(2);

    // R11 unmapped
    wr(12'h010, 32'hFFFF_FFFF);
    rd(12'h010, "R11 unmapped");
    rd(A_CLR, "R11 ack reads zero");
    rd(A_CTRL, "R11 ctrl untouched");

    // Random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4)
        wr(A_LOCK, ($urandom_range(0, 9) < 8) ? KEY : $urandom());
      else if (r < 9)
        wr(A_CTRL, {$urandom_range(0, 1) ? $urandom() : 32'h0} | 32'($urandom_range(0, 3)));
      else if (r < 14)
        wr(A_LOAD, ($urandom_range(0, 19) == 0) ? $urandom() : 32'($urandom_range(0, 12)));
      else if (r < 18)
        wr(A_CLR, $urandom());
      else if (r < 19)
        wr(12'($urandom_range(0, 4095)), $urandom());
      else if (r < 35) begin
        logic [11:0] a;
        case ($urandom_range(0, 6))
          0: a = A_LOAD; 1: a = A_VAL; 2: a = A_CTRL; 3: a = A_CLR;
          4: a = A_STAT; 5: a = A_LOCK; default: a = 12'h3F0;
        endcase
        rd(a, "R5 random read");
      end else
        idle(1);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule